// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Responder

This block is the low-power front end of a serial memory slave. It watches a mode-0 serial bus (active-low select, a serial clock that idles low, one data line in, one data line out) by oversampling it in the system clock domain. It decodes two one-byte commands. One parks the part in deep power-down. The other wakes the part and returns an identification byte. While the part is powered down, every other command is ignored.

The wake/identify command is followed by three dummy bytes. After them the part shifts out a fixed signature byte, most significant bit first, and repeats it for as long as the host keeps clocking. When select is released, a part that was powered down passes through a timed wake window before it returns to standby. That window is short if select rose before the first signature byte was complete, and long otherwise. A part that was not powered down returns to standby at once. A busy flag from an external write/erase engine suppresses decoding. Selecting the part during a wake window is flagged as a timing violation, and that access is ignored.

There is no data stream with back-pressure here: the serial pins are plain level signals sampled every system clock. The output enable stands in for a tri-state driver.

Top module: `spi_dpd_responder`

## Requirements
- R1: After reset, `pwr_state` reads standby (encoding: 0 standby, 1 selected, 2 powered down, 3 waking), and `spi_miso_oe` and `timing_viol` are low.
- R2: With `wr_busy` low, opcode 0xB9 shifted in MSB first, followed by select rising after exactly 8 serial clocks, moves the part from selected (1) to powered down (2).
- R3: While powered down, any opcode other than 0xAB leaves the state at 2 and never enables the data output.
- R4: After opcode 0xAB and three dummy bytes, the signature 0x05 is driven MSB first, with each bit updated after a falling serial clock edge. Further clocks repeat the byte.
- R5: When the part was powered down and select rises after at least one whole signature byte, the state is waking (3) for WAKE_LONG_CYC system clocks and then standby.
- R6: When the part was powered down and select rises after the 0xAB opcode byte but before the first signature byte completes, the waking state lasts WAKE_SHORT_CYC system clocks.
- R7: 0xAB issued while not powered down returns the signature, and select rising puts the part straight into standby with no waking state.
- R8: If `wr_busy` is high when the opcode byte completes, 0xAB is not decoded: no output is driven and the state is unchanged.
- R9: Select falling during the waking state raises `timing_viol` for one clock, and that whole access is ignored. The wake window still ends in standby.
- R10: Select rising at any point other than exactly 8 bits after 0xB9 does not enter power-down. An incomplete 0xAB while powered down leaves the state at 2.
- R11: `spi_miso_oe` is low while select is high and stays low until the first signature bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the part |
| spi_miso | output | 1 | Serial data out of the part |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` (low means high-impedance) |
| wr_busy | input | 1 | Write/erase/program cycle in progress |
| pwr_state | output | 2 | Power state, encoded as in R1 |
| timing_viol | output | 1 | One-cycle pulse on select during a wake window |

## Verification
The bench builds the block with a two-stage synchronizer, a 20-cycle short wake window and a 60-cycle long one, and drives the serial clock at 12 system clocks per bit. The short windows let it sample inside and just after both delays. Because the two delays differ so much, a single sample 26 clocks after select rises tells them apart. It also lets the bench drop select in the middle of a wake window and hold a full access across the window's expiry, which shows that the ignored access stays ignored.

// File: rtl/spi_dpd_pkg.sv
package spi_dpd_pkg;

  typedef enum logic [1:0] {
    PWR_STANDBY  = 2'd0,
    PWR_SELECTED = 2'd1,
    PWR_DOWN     = 2'd2,
    PWR_WAKING   = 2'd3
  } pwr_state_e;

  localparam logic [7:0] OPC_WAKE_ID  = 8'hAB;
  localparam logic [7:0] OPC_SLEEP    = 8'hB9;
  localparam logic [7:0] ID_SIGNATURE = 8'h05;

endpackage

// File: rtl/spi_dpd_sync.sv
module spi_dpd_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_dpd_frontend.sv
module spi_dpd_frontend #(
  parameter int         DUMMY_BYTES = 3,
  parameter logic [7:0] SIG_VALUE   = 8'h05,
  parameter logic [7:0] OPC_WAKE    = 8'hAB,
  parameter logic [7:0] OPC_SLEEP   = 8'hB9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic mosi_s,
  input  logic busy,
  input  logic block,
  output logic wake_cmd,
  output logic sleep_ok,
  output logic sig_done,
  output logic miso,
  output logic miso_oe
);

  localparam int              SIG_BYTE = DUMMY_BYTES + 1;
  localparam int              BCW      = $clog2(SIG_BYTE + 1);
  localparam logic [BCW-1:0]  SIG_IDX  = BCW'(SIG_BYTE);
  localparam logic [BCW-1:0]  ONE_BYTE = BCW'(1);

  logic [2:0]     bit_cnt;
  logic [BCW-1:0] byte_cnt;
  logic [6:0]     shreg;
  logic           wake_q, sleep_q, done_q, oe_q, miso_q;
  logic [7:0]     opcode;

  assign opcode = {shreg, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      wake_q   <= 1'b0;
      sleep_q  <= 1'b0;
      done_q   <= 1'b0;
      oe_q     <= 1'b0;
      miso_q   <= 1'b0;
    end else if (cs_s) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      wake_q   <= 1'b0;
      sleep_q  <= 1'b0;
      done_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg   <= opcode[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != SIG_IDX) byte_cnt <= byte_cnt + ONE_BYTE;
          if (byte_cnt == '0 && !busy && !block) begin
            wake_q  <= (opcode == OPC_WAKE);
            sleep_q <= (opcode == OPC_SLEEP);
          end
          if (byte_cnt == SIG_IDX && wake_q) done_q <= 1'b1;
        end
      end
      if (sck_fall && wake_q && byte_cnt == SIG_IDX) begin
        miso_q <= SIG_VALUE[3'd7 - bit_cnt];
        oe_q   <= 1'b1;
      end
    end
  end

  assign wake_cmd = wake_q;
  assign sleep_ok = sleep_q && bit_cnt == 3'd0 && byte_cnt == ONE_BYTE;
  assign sig_done = done_q;
  assign miso     = miso_q;
  assign miso_oe  = oe_q;

endmodule

// File: rtl/spi_dpd_power.sv
module spi_dpd_power
  import spi_dpd_pkg::*;
#(
  parameter int WAKE_SHORT_CYC = 200,
  parameter int WAKE_LONG_CYC  = 1800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       wake_cmd,
  input  logic       sig_done,
  input  logic       sleep_ok,
  output pwr_state_e state,
  output logic       block,
  output logic       viol
);

  localparam int TMAX = (WAKE_SHORT_CYC > WAKE_LONG_CYC) ? WAKE_SHORT_CYC : WAKE_LONG_CYC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PWR_STANDBY;
      wake_cnt <= '0;
      block    <= 1'b0;
      viol     <= 1'b0;
    end else begin
      viol <= 1'b0;
      if (cs_rise) block <= 1'b0;
      unique case (state)
        PWR_STANDBY: if (cs_fall) state <= PWR_SELECTED;
        PWR_SELECTED: if (cs_rise) state <= sleep_ok ? PWR_DOWN : PWR_STANDBY;
        PWR_DOWN: begin
          if (cs_rise && wake_cmd) begin
            state    <= PWR_WAKING;
            wake_cnt <= sig_done ? CW'(WAKE_LONG_CYC) : CW'(WAKE_SHORT_CYC);
          end
        end
        PWR_WAKING: begin
          if (wake_cnt <= CNT_ONE) state <= PWR_STANDBY;
          else                     wake_cnt <= wake_cnt - CNT_ONE;
          if (cs_fall) begin
            viol  <= 1'b1;
            block <= 1'b1;
          end
        end
        default: state <= PWR_STANDBY;
      endcase
    end
  end

endmodule

// File: rtl/spi_dpd_responder.sv
module spi_dpd_responder
  import spi_dpd_pkg::*;
#(
  parameter int         SYNC_STAGES    = 2,
  parameter int         DUMMY_BYTES    = 3,
  parameter int         WAKE_SHORT_CYC = 200,
  parameter int         WAKE_LONG_CYC  = 1800,
  parameter logic [7:0] SIG_VALUE      = ID_SIGNATURE,
  parameter logic [7:0] OPC_WAKE       = OPC_WAKE_ID,
  parameter logic [7:0] OPC_DOWN       = OPC_SLEEP
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic       wr_busy,
  output logic [1:0] pwr_state,
  output logic       timing_viol
);

  localparam logic [2:0] PIN_RST = 3'b001;

  logic [2:0] pins_s;
  logic       cs_s, sck_s, mosi_s;
  logic       cs_q, sck_q;
  logic       cs_rise, cs_fall, sck_rise, sck_fall;
  logic       wake_cmd, sleep_ok, sig_done, block;
  pwr_state_e state;

  spi_dpd_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_mosi, spi_sck, spi_cs_n}),
    .dout (pins_s)
  );

  assign cs_s   = pins_s[0];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign cs_rise  = cs_s & ~cs_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_s;

  spi_dpd_frontend #(
    .DUMMY_BYTES(DUMMY_BYTES),
    .SIG_VALUE  (SIG_VALUE),
    .OPC_WAKE   (OPC_WAKE),
    .OPC_SLEEP  (OPC_DOWN)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .mosi_s  (mosi_s),
    .busy    (wr_busy),
    .block   (block),
    .wake_cmd(wake_cmd),
    .sleep_ok(sleep_ok),
    .sig_done(sig_done),
    .miso    (spi_miso),
    .miso_oe (spi_miso_oe)
  );

  spi_dpd_power #(
    .WAKE_SHORT_CYC(WAKE_SHORT_CYC),
    .WAKE_LONG_CYC (WAKE_LONG_CYC)
  ) u_power (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_fall (cs_fall),
    .cs_rise (cs_rise),
    .wake_cmd(wake_cmd),
    .sig_done(sig_done),
    .sleep_ok(sleep_ok),
    .state   (state),
    .block   (block),
    .viol    (timing_viol)
  );

  assign pwr_state = state;

endmodule

// File: rtl/spi_dpd_checker.sv
module spi_dpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       sck_fall,
  input logic       miso,
  input logic       oe,
  input logic [1:0] state,
  input logic       viol
);

  p_hiz_cs_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !oe);

  p_miso_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sck_fall));

  p_down_from_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && $past(state) != 2'd2) |-> $past(state) == 2'd1);

  p_down_exits_to_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd2 && state != 2'd2) |-> state == 2'd3);

  p_wake_from_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && $past(state) != 2'd3) |-> $past(state) == 2'd2);

  p_viol_in_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(state) == 2'd3);

endmodule

bind spi_dpd_responder spi_dpd_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_s    (cs_s),
  .sck_fall(sck_fall),
  .miso    (spi_miso),
  .oe      (spi_miso_oe),
  .state   (pwr_state),
  .viol    (timing_viol)
);

// File: tb/tb_spi_dpd_responder.sv
module tb_spi_dpd_responder;

  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 6;
  localparam int         T_SHORT    = 20;
  localparam int         T_LONG     = 60;
  localparam logic [7:0] SIG        = 8'h05;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic       miso, miso_oe, viol;
  logic [1:0] pstate;

  int n_checks = 0, n_fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int viol_cnt = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_dpd_responder #(
    .SYNC_STAGES   (2),
    .DUMMY_BYTES   (3),
    .WAKE_SHORT_CYC(T_SHORT),
    .WAKE_LONG_CYC (T_LONG)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (cs_n),
    .spi_sck    (sck),
    .spi_mosi   (mosi),
    .spi_miso   (miso),
    .spi_miso_oe(miso_oe),
    .wr_busy    (busy),
    .pwr_state  (pstate),
    .timing_viol(viol)
  );

  always @(posedge clk) if (viol) viol_cnt++;

  // Monitor: pops one expectation per rising serial clock edge
  always @(posedge sck) begin
    if (exp_q.size() != 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      mon_checks++;
      if (e == 2'd2) begin
        if (miso_oe !== 1'b0) begin
          mon_fails++;
          $display("FAIL %s: miso_oe=%b expected 0", t, miso_oe);
        end
      end else if (miso_oe !== 1'b1 || miso !== e[0]) begin
        mon_fails++;
        $display("FAIL %s: oe=%b miso=%b expected oe=1 miso=%b", t, miso_oe, miso, e[0]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_high();
    tick(HALF);
    cs_n = 1'b1;
  endtask

  task automatic shift_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7 - i];
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  // Driver: pushes the expected output bit (2 = high-impedance) before each rise
  task automatic read_sig(input int nbits, input bit driven, input string tag);
    for (int i = 0; i < nbits; i++) begin
      exp_q.push_back(driven ? {1'b0, SIG[7 - (i % 8)]} : 2'd2);
      tag_q.push_back(tag);
      mosi = 1'b0;
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic wake_prefix();
    shift_bits(8'hAB, 8);
    for (int d = 0; d < 3; d++) shift_bits(8'h00, 8);
  endtask

  task automatic enter_down();
    cs_low();
    shift_bits(8'hB9, 8);
    cs_high();
    tick(5);
    chk("R2 enter power-down", pstate, 2);
  endtask

  initial begin : watchdog
    tick(150000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks + mon_checks + 1, n_fails + mon_fails);
    $finish;
  end

  initial begin : main
    tick(4);
    rst_n = 1'b1;
    tick(3);
    chk("R1 reset state", pstate, 0);
    chk("R1 reset oe", miso_oe, 0);
    chk("R1 reset viol", viol, 0);

    // R7: identify from standby, signature repeated, immediate standby
    cs_low();
    tick(2);
    chk("R7 selected", pstate, 1);
    chk("R11 oe before signature", miso_oe, 0);
    wake_prefix();
    read_sig(16, 1'b1, "R4 R7 signature");
    cs_high();
    tick(5);
    chk("R7 immediate standby", pstate, 0);
    chk("R11 oe low after deselect", miso_oe, 0);

    // R10: sleep opcode with one extra bit does not enter power-down
    cs_low();
    shift_bits(8'hB9, 8);
    shift_bits(8'h00, 1);
    cs_high();
    tick(5);
    chk("R10 off-boundary sleep", pstate, 0);

    enter_down();

    // R3: other opcodes ignored while powered down
    cs_low();
    shift_bits(8'h9F, 8);
    for (int d = 0; d < 3; d++) shift_bits(8'h00, 8);
    read_sig(8, 1'b0, "R3 no output in power-down");
    cs_high();
    tick(30);
    chk("R3 stays down after other opcode", pstate, 2);
    cs_low();
    shift_bits(8'hB9, 8);
    cs_high();
    tick(30);
    chk("R3 repeated sleep ignored", pstate, 2);

    // R10: truncated identify opcode while powered down
    cs_low();
    shift_bits(8'hAB, 4);
    cs_high();
    tick(30);
    chk("R10 partial opcode stays down", pstate, 2);

    // R8: busy suppresses the identify command
    busy = 1'b1;
    cs_low();
    wake_prefix();
    read_sig(8, 1'b0, "R8 busy no output");
    cs_high();
    tick(30);
    chk("R8 busy stays down", pstate, 2);
    busy = 1'b0;

    // R6: deselect right after the opcode gives the short window
    cs_low();
    shift_bits(8'hAB, 8);
    cs_high();
    tick(5);
    chk("R6 waking", pstate, 3);
    tick(13);
    chk("R6 still waking at 18", pstate, 3);
    tick(8);
    chk("R6 standby at 26", pstate, 0);

    // R6: deselect partway through the first signature byte
    enter_down();
    cs_low();
    wake_prefix();
    read_sig(4, 1'b1, "R4 partial signature");
    cs_high();
    tick(18);
    chk("R6 partial signature still waking", pstate, 3);
    tick(8);
    chk("R6 partial signature standby", pstate, 0);

    // R5: full signature gives the long window
    enter_down();
    cs_low();
    wake_prefix();
    read_sig(8, 1'b1, "R4 R5 signature from power-down");
    cs_high();
    tick(26);
    chk("R5 still waking at 26", pstate, 3);
    tick(32);
    chk("R5 still waking at 58", pstate, 3);
    tick(8);
    chk("R5 standby at 66", pstate, 0);

    // R9: select during the wake window
    enter_down();
    cs_low();
    shift_bits(8'hAB, 8);
    cs_high();
    chk("R9 no violation yet", viol_cnt, 0);
    tick(6);
    cs_low();
    tick(4);
    chk("R9 violation flagged", viol_cnt, 1);
    wake_prefix();
    read_sig(8, 1'b0, "R9 ignored access");
    chk("R9 window expired to standby", pstate, 0);
    cs_high();
    tick(5);
    chk("R9 standby after ignored access", pstate, 0);
    chk("R9 single violation pulse", viol_cnt, 1);
    cs_low();
    wake_prefix();
    read_sig(8, 1'b1, "R9 next access served");
    cs_high();
    tick(5);
    chk("R9 standby after served access", pstate, 0);
    chk("R9 no further violation", viol_cnt, 1);

    tick(10);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks + mon_checks, n_fails + mon_fails);
    $finish;
  end

endmodule